// File: doc/BRIEF.md
# Floating-point invalid-operation status classifier

This unit sits next to a double-precision arithmetic core and turns the core's coarse status into detailed status for the floating-point status register. The core reports only two raw flags, "invalid" and "divide by zero". The unit takes those flags, the operation code and both 64-bit operands. From the operand classes it works out which specific invalid-operation cause applies. It also decides whether the zero-divide bit is set, whether the enabled-exception summary is raised, and whether a program trap is requested.

Every accepted operation (`in_valid` high) gives, one clock later, a one-cycle `out_valid` strobe. The cause, zero-divide, summary and trap bits come as pulses on that strobe. The result passes through, with one exception: a reciprocal estimate that divides by zero returns a signed one-half. Sticky copies of the cause, zero-divide and summary bits are kept. They are only ever set, and only reset clears them. A build-time parameter selects a user-level configuration in which trapping is always armed.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset every output is zero: strobe, pulses, trap request, result and all sticky bits.
- R2: `out_valid` pulses exactly one cycle after a cycle with `in_valid` high, and all pulses appear only with it. When `raw_invalid` is low, no cause bit is set. Cause vector bits: [0] inf minus inf, [1] signalling NaN, [2] zero times inf, [3] inf over inf, [4] zero over zero, [5] square root of negative. Op codes: 0 add, 1 sub, 2 mul, 3 div, 4 sqrt, 5 reciprocal estimate, 6 reciprocal square-root estimate, 7 none; op 7 sets no cause and no zero-divide bit.
- R3: For add or sub with `raw_invalid`, both operands infinite set bit 0. Otherwise, if either operand is a signalling NaN, bit 1 is set. A signalling NaN has exponent all ones, a non-zero fraction and fraction MSB 0. Infinity has exponent all ones and a zero fraction. Zero has exponent and fraction both zero, with either sign.
- R4: For mul with `raw_invalid`, one operand infinite and the other zero sets bit 2. Otherwise a signalling-NaN operand sets bit 1.
- R5: For div with `raw_invalid` the checks run in priority order: both infinite sets bit 3, then both zero sets bit 4, then a signalling-NaN operand sets bit 1.
- R6: For sqrt with `raw_invalid`, a NaN operand A sets bit 1 only if it is signalling, and a quiet NaN sets nothing. A non-NaN A sets bit 5.
- R7: For the reciprocal square-root estimate with `raw_invalid`, a signalling-NaN A sets bit 1 and any other A sets bit 5. For the reciprocal estimate, only a signalling-NaN A sets a cause (bit 1).
- R8: `zdiv_pulse` follows `raw_divzero` for div, reciprocal estimate and reciprocal square-root estimate only.
- R9: `summary_pulse` is set when any cause bit is set with `inv_en` high, or when the zero-divide bit is set with `zdiv_en` high.
- R10: `trap_req` equals the summary pulse gated by (`trap_mode0` OR `trap_mode1`). With parameter USER_ONLY=1 the gate is always open.
- R11: A reciprocal estimate with `raw_divzero` returns 64'h3FE0000000000000 with the sign of operand A. Every other result equals `core_result`.
- R12: The sticky cause, zero-divide and summary bits gather every pulse and never clear outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation completes this cycle |
| op | input | 3 | Operation code |
| opnd_a | input | 64 | First operand (only operand for unary ops) |
| opnd_b | input | 64 | Second operand |
| core_result | input | 64 | Result from the arithmetic core |
| raw_invalid | input | 1 | Core's generic invalid flag |
| raw_divzero | input | 1 | Core's divide-by-zero flag |
| inv_en | input | 1 | Invalid-operation enable |
| zdiv_en | input | 1 | Zero-divide enable |
| trap_mode0 | input | 1 | Trap-mode state bit 0 |
| trap_mode1 | input | 1 | Trap-mode state bit 1 |
| out_valid | output | 1 | Result and pulses valid |
| out_result | output | 64 | Final result |
| cause_pulse | output | 6 | Invalid cause pulses |
| zdiv_pulse | output | 1 | Zero-divide pulse |
| summary_pulse | output | 1 | Enabled-exception summary pulse |
| trap_req | output | 1 | Program trap request |
| sticky_cause | output | 6 | Sticky cause bits |
| sticky_zdiv | output | 1 | Sticky zero-divide bit |
| sticky_summary | output | 1 | Sticky summary bit |

## Verification
Every result of this block, including the sticky bits, is due exactly one clock edge after the cycle in which `in_valid` was sampled high. The outputs return to zero, apart from the sticky bits and the result, on the following edge. The bench drives each operation on a falling edge and compares every output on the next falling edge, which falls after the single register stage. It then drops `in_valid` and, on idle cycles, checks that the strobe and pulses are low. Randomly chosen operand classes are mixed with directed priority cases for each op.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int NCAUSE = 6;

  // cause vector bit positions
  localparam int C_INF_SUB  = 0;
  localparam int C_SNAN     = 1;
  localparam int C_ZERO_INF = 2;
  localparam int C_INF_DIV  = 3;
  localparam int C_ZERO_DIV = 4;
  localparam int C_SQRT_NEG = 5;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_MUL   = 3'd2,
    OP_DIV   = 3'd3,
    OP_SQRT  = 3'd4,
    OP_RECIP = 3'd5,
    OP_RSQRT = 3'd6,
    OP_NONE  = 3'd7
  } fpx_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic nan;
    logic snan;
  } fpx_cls_t;
endpackage

// File: rtl/fpx_classify.sv
`timescale 1ns/1ps
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0] word,
  output fpx_cls_t       cls
);
  localparam int TOP_BIT = EW + FW;

  logic [EW-1:0] expo;
  logic [FW-1:0] frac;
  logic          exp_max;
  logic          exp_min;
  logic          frac_nz;

  always_comb begin
    expo    = word[TOP_BIT-1 -: EW];
    frac    = word[FW-1:0];
    exp_max = &expo;
    exp_min = ~|expo;
    frac_nz = |frac;
    cls.sign = word[TOP_BIT];
    cls.zero = exp_min & ~frac_nz;
    cls.inf  = exp_max & ~frac_nz;
    cls.nan  = exp_max & frac_nz;
    cls.snan = exp_max & frac_nz & ~frac[FW-1];
  end
endmodule

// File: rtl/fpx_cause_sel.sv
`timescale 1ns/1ps
module fpx_cause_sel
  import fpx_pkg::*;
#(
  parameter int NC = NCAUSE
) (
  input  logic [2:0]    op,
  input  fpx_cls_t      cls_a,
  input  fpx_cls_t      cls_b,
  input  logic          raw_invalid,
  input  logic          raw_divzero,
  output logic [NC-1:0] cause,
  output logic          zdiv
);
  logic any_snan;
  logic both_inf;
  logic both_zero;
  logic inf_zero_mix;

  always_comb begin
    any_snan     = cls_a.snan | cls_b.snan;
    both_inf     = cls_a.inf & cls_b.inf;
    both_zero    = cls_a.zero & cls_b.zero;
    inf_zero_mix = (cls_a.inf & cls_b.zero) | (cls_a.zero & cls_b.inf);
    cause = '0;
    zdiv  = 1'b0;
    if (raw_invalid) begin
      unique case (fpx_op_e'(op))
        OP_ADD, OP_SUB: begin
          if (both_inf)      cause[C_INF_SUB] = 1'b1;
          else if (any_snan) cause[C_SNAN]    = 1'b1;
        end
        OP_MUL: begin
          if (inf_zero_mix)  cause[C_ZERO_INF] = 1'b1;
          else if (any_snan) cause[C_SNAN]     = 1'b1;
        end
        OP_DIV: begin
          if (both_inf)       cause[C_INF_DIV]  = 1'b1;
          else if (both_zero) cause[C_ZERO_DIV] = 1'b1;
          else if (any_snan)  cause[C_SNAN]     = 1'b1;
        end
        OP_SQRT: begin
          if (cls_a.nan) cause[C_SNAN]     = cls_a.snan;
          else           cause[C_SQRT_NEG] = 1'b1;
        end
        OP_RECIP: begin
          cause[C_SNAN] = cls_a.snan;
        end
        OP_RSQRT: begin
          if (cls_a.snan) cause[C_SNAN]     = 1'b1;
          else            cause[C_SQRT_NEG] = 1'b1;
        end
        default: cause = '0;
      endcase
    end
    unique case (fpx_op_e'(op))
      OP_DIV, OP_RECIP, OP_RSQRT: zdiv = raw_divzero;
      default:                    zdiv = 1'b0;
    endcase
  end

  // R2
  always_comb begin
    onehot_cause_chk: assert ($onehot0(cause));
  end
endmodule

// File: rtl/fpx_flag_gate.sv
`timescale 1ns/1ps
module fpx_flag_gate
  import fpx_pkg::*;
#(
  parameter int NC        = NCAUSE,
  parameter int W         = WORD_W,
  parameter bit USER_ONLY = 1'b0
) (
  input  logic [2:0]    op,
  input  logic [NC-1:0] cause,
  input  logic          zdiv,
  input  logic          inv_en,
  input  logic          zdiv_en,
  input  logic          trap_mode0,
  input  logic          trap_mode1,
  input  logic          sign_a,
  input  logic [W-1:0]  core_result,
  output logic          summary,
  output logic          trap,
  output logic [W-1:0]  result
);
  localparam int FW = W - 1 - EXP_W;
  // exponent field of one half: bias minus one
  localparam logic [EXP_W-1:0] HALF_EXP = {1'b0, {(EXP_W-2){1'b1}}, 1'b0};

  logic arm;

  generate
    if (USER_ONLY) begin : g_user
      assign arm = 1'b1;
    end else begin : g_priv
      assign arm = trap_mode0 | trap_mode1;
    end
  endgenerate

  always_comb begin
    summary = ((|cause) & inv_en) | (zdiv & zdiv_en);
    trap    = summary & arm;
    if (fpx_op_e'(op) == OP_RECIP && zdiv)
      result = {sign_a, HALF_EXP, {FW{1'b0}}};
    else
      result = core_result;
  end

  // R10
  always_comb begin
    trap_needs_sum_chk: assert (!trap || summary);
  end
endmodule

// File: rtl/fpx_status_unit.sv
`timescale 1ns/1ps
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter bit USER_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [WORD_W-1:0] core_result,
  input  logic              raw_invalid,
  input  logic              raw_divzero,
  input  logic              inv_en,
  input  logic              zdiv_en,
  input  logic              trap_mode0,
  input  logic              trap_mode1,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic [NCAUSE-1:0] cause_pulse,
  output logic              zdiv_pulse,
  output logic              summary_pulse,
  output logic              trap_req,
  output logic [NCAUSE-1:0] sticky_cause,
  output logic              sticky_zdiv,
  output logic              sticky_summary
);
  localparam int NOPND = 2;

  fpx_cls_t          cls [NOPND];
  logic [NCAUSE-1:0] cause_c;
  logic              zdiv_c;
  logic              sum_c;
  logic              trap_c;
  logic [WORD_W-1:0] res_c;

  generate
    for (genvar i = 0; i < NOPND; i++) begin : g_cls
      fpx_classify u_cls (
        .word (i == 0 ? opnd_a : opnd_b),
        .cls  (cls[i])
      );
    end
  endgenerate

  fpx_cause_sel u_sel (
    .op          (op),
    .cls_a       (cls[0]),
    .cls_b       (cls[1]),
    .raw_invalid (raw_invalid),
    .raw_divzero (raw_divzero),
    .cause       (cause_c),
    .zdiv        (zdiv_c)
  );

  fpx_flag_gate #(.USER_ONLY(USER_ONLY)) u_gate (
    .op          (op),
    .cause       (cause_c),
    .zdiv        (zdiv_c),
    .inv_en      (inv_en),
    .zdiv_en     (zdiv_en),
    .trap_mode0  (trap_mode0),
    .trap_mode1  (trap_mode1),
    .sign_a      (cls[0].sign),
    .core_result (core_result),
    .summary     (sum_c),
    .trap        (trap_c),
    .result      (res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_result     <= '0;
      cause_pulse    <= '0;
      zdiv_pulse     <= 1'b0;
      summary_pulse  <= 1'b0;
      trap_req       <= 1'b0;
      sticky_cause   <= '0;
      sticky_zdiv    <= 1'b0;
      sticky_summary <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      cause_pulse   <= in_valid ? cause_c : '0;
      zdiv_pulse    <= in_valid & zdiv_c;
      summary_pulse <= in_valid & sum_c;
      trap_req      <= in_valid & trap_c;
      if (in_valid) begin
        out_result     <= res_c;
        sticky_cause   <= sticky_cause | cause_c;
        sticky_zdiv    <= sticky_zdiv | zdiv_c;
        sticky_summary <= sticky_summary | sum_c;
      end
    end
  end

  // R2
  pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (|cause_pulse || zdiv_pulse || summary_pulse || trap_req) |-> out_valid);

  // R2
  no_invalid_no_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !raw_invalid) |=> cause_pulse == '0);

  // R8
  zdiv_op_scope_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_ADD || op == OP_SUB || op == OP_MUL || op == OP_SQRT))
    |=> !zdiv_pulse);

  // R9
  summary_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    summary_pulse |-> (|cause_pulse || zdiv_pulse));

  // R12
  sticky_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    ((sticky_cause & $past(sticky_cause)) == $past(sticky_cause))
    && (sticky_zdiv || !$past(sticky_zdiv))
    && (sticky_summary || !$past(sticky_summary)));

  // R12
  sticky_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(sticky_cause) && $stable(sticky_zdiv) && $stable(sticky_summary)));
endmodule

// File: tb/sim_fpx_status_unit.sv
`timescale 1ns/1ps
module sim_fpx_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0, core_result = '0;
  logic        raw_invalid = 1'b0, raw_divzero = 1'b0;
  logic        inv_en = 1'b0, zdiv_en = 1'b0, trap_mode0 = 1'b0, trap_mode1 = 1'b0;

  logic        out_valid, zdiv_pulse, summary_pulse, trap_req, sticky_zdiv, sticky_summary;
  logic [63:0] out_result;
  logic [5:0]  cause_pulse, sticky_cause;
  logic        out_valid1, zdiv1, sum1, trap1, sz1, ss1;
  logic [63:0] res1;
  logic [5:0]  cause1, sc1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [5:0] exp_sc = '0;
  logic       exp_sz = 1'b0, exp_ss = 1'b0;

  always #2.5 clk = ~clk;

  fpx_status_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .core_result(core_result), .raw_invalid(raw_invalid), .raw_divzero(raw_divzero),
    .inv_en(inv_en), .zdiv_en(zdiv_en), .trap_mode0(trap_mode0), .trap_mode1(trap_mode1),
    .out_valid(out_valid), .out_result(out_result), .cause_pulse(cause_pulse),
    .zdiv_pulse(zdiv_pulse), .summary_pulse(summary_pulse), .trap_req(trap_req),
    .sticky_cause(sticky_cause), .sticky_zdiv(sticky_zdiv), .sticky_summary(sticky_summary));

  fpx_status_unit #(.USER_ONLY(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .core_result(core_result), .raw_invalid(raw_invalid), .raw_divzero(raw_divzero),
    .inv_en(inv_en), .zdiv_en(zdiv_en), .trap_mode0(trap_mode0), .trap_mode1(trap_mode1),
    .out_valid(out_valid1), .out_result(res1), .cause_pulse(cause1),
    .zdiv_pulse(zdiv1), .summary_pulse(sum1), .trap_req(trap1),
    .sticky_cause(sc1), .sticky_zdiv(sz1), .sticky_summary(ss1));

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (op %0d a %h b %h)", req, got, exp, op, opnd_a, opnd_b);
    end
  endtask

  // operand maker: 0 zero, 1 inf, 2 quiet NaN, 3 signalling NaN, 4 normal, 5 subnormal
  function automatic logic [63:0] mk(int k, bit s);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (k)
      0: return {s, 63'd0};
      1: return {s, 11'h7FF, 52'd0};
      2: return {s, 11'h7FF, 1'b1, r[50:0]};
      3: return {s, 11'h7FF, 1'b0, r[50:1], 1'b1};
      4: return {s, 11'h3FF, r[51:0]};
      default: return {s, 11'h000, r[51:1], 1'b1};
    endcase
  endfunction

  function automatic bit is_inf(logic [63:0] x);  return x[62:52] == 11'h7FF && x[51:0] == 0; endfunction
  function automatic bit is_zero(logic [63:0] x); return x[62:0] == 0; endfunction
  function automatic bit is_nan(logic [63:0] x);  return x[62:52] == 11'h7FF && x[51:0] != 0; endfunction
  function automatic bit is_snan(logic [63:0] x); return is_nan(x) && !x[51]; endfunction

  function automatic logic [5:0] ref_cause(logic [2:0] o, logic [63:0] a, logic [63:0] b, bit inv);
    logic [5:0] c = '0;
    bit sn = is_snan(a) || is_snan(b);
    if (!inv) return c;
    if (o == 0 || o == 1) begin
      if (is_inf(a) && is_inf(b)) c[0] = 1; else if (sn) c[1] = 1;
    end else if (o == 2) begin
      if ((is_inf(a) && is_zero(b)) || (is_zero(a) && is_inf(b))) c[2] = 1; else if (sn) c[1] = 1;
    end else if (o == 3) begin
      if (is_inf(a) && is_inf(b)) c[3] = 1;
      else if (is_zero(a) && is_zero(b)) c[4] = 1;
      else if (sn) c[1] = 1;
    end else if (o == 4) begin
      if (is_nan(a)) c[1] = is_snan(a); else c[5] = 1;
    end else if (o == 5) begin
      c[1] = is_snan(a);
    end else if (o == 6) begin
      if (is_snan(a)) c[1] = 1; else c[5] = 1;
    end
    return c;
  endfunction

  // one operation: drive on a falling edge, compare on the next falling edge
  task automatic txn(logic [2:0] o, logic [63:0] a, logic [63:0] b, bit inv, bit dz,
                     bit ie, bit ze, bit t0, bit t1, string tag);
    logic [5:0]  ec;
    logic        ez, es, et;
    logic [63:0] er;
    logic [63:0] cr;
    cr = {$urandom, $urandom};
    op = o; opnd_a = a; opnd_b = b; raw_invalid = inv; raw_divzero = dz;
    inv_en = ie; zdiv_en = ze; trap_mode0 = t0; trap_mode1 = t1; core_result = cr;
    in_valid = 1'b1;
    ec = ref_cause(o, a, b, inv);
    ez = dz && (o == 3 || o == 5 || o == 6);
    es = ((|ec) && ie) || (ez && ze);
    et = es && (t0 || t1);
    er = (o == 5 && ez) ? {a[63], 11'h3FE, 52'd0} : cr;
    exp_sc |= ec; exp_sz |= ez; exp_ss |= es;
    @(negedge clk);
    in_valid = 1'b0;
    check({"R2 valid ", tag}, 64'(out_valid), 64'd1);
    check({"R3-7 cause ", tag}, 64'(cause_pulse), 64'(ec));
    check({"R8 zdiv ", tag}, 64'(zdiv_pulse), 64'(ez));
    check({"R9 summary ", tag}, 64'(summary_pulse), 64'(es));
    check({"R10 trap ", tag}, 64'(trap_req), 64'(et));
    check({"R10 user trap ", tag}, 64'(trap1), 64'(es));
    check({"R11 result ", tag}, out_result, er);
    check({"R12 sticky ", tag}, 64'({sticky_cause, sticky_zdiv, sticky_summary}),
          64'({exp_sc, exp_sz, exp_ss}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", 64'({out_valid, cause_pulse, zdiv_pulse, summary_pulse, trap_req,
          sticky_cause, sticky_zdiv, sticky_summary}), 64'd0);
    check("R1 reset result", out_result, 64'd0);

    // directed corners
    txn(3'd0, mk(1,0), mk(1,1), 1, 0, 1, 0, 0, 0, "R3 inf-inf");
    txn(3'd1, mk(3,0), mk(1,0), 1, 0, 1, 0, 1, 0, "R3 snan priority after inf");
    txn(3'd0, mk(2,0), mk(4,0), 1, 0, 1, 0, 0, 1, "R3 qnan no cause");
    txn(3'd2, mk(1,0), mk(0,1), 1, 0, 1, 0, 1, 0, "R4 inf*zero");
    txn(3'd2, mk(0,0), mk(3,0), 1, 0, 0, 0, 1, 0, "R4 snan");
    txn(3'd3, mk(1,0), mk(1,0), 1, 0, 1, 0, 1, 0, "R5 inf/inf");
    txn(3'd3, mk(0,0), mk(0,1), 1, 0, 1, 0, 0, 0, "R5 0/0");
    txn(3'd3, mk(3,0), mk(0,0), 1, 1, 0, 1, 1, 1, "R5 snan and zdiv");
    txn(3'd4, mk(4,1), mk(4,0), 1, 0, 1, 0, 1, 0, "R6 sqrt neg");
    txn(3'd4, mk(2,0), mk(4,0), 1, 0, 1, 0, 1, 0, "R6 sqrt qnan");
    txn(3'd6, mk(4,1), mk(4,0), 1, 0, 1, 0, 0, 0, "R7 rsqrt neg");
    txn(3'd6, mk(0,0), mk(4,0), 0, 1, 0, 1, 1, 0, "R8 rsqrt zdiv");
    txn(3'd5, mk(0,1), mk(4,0), 0, 1, 0, 0, 0, 0, "R11 recip half neg");
    txn(3'd5, mk(0,0), mk(4,0), 0, 1, 0, 1, 0, 0, "R11 recip half pos");
    txn(3'd0, mk(1,0), mk(1,1), 0, 1, 1, 1, 1, 1, "R2 no invalid");
    txn(3'd7, mk(3,0), mk(1,0), 1, 1, 1, 1, 1, 1, "R2 op none");

    // idle cycle: strobe and pulses low
    @(negedge clk);
    check("R2 idle", 64'({out_valid, cause_pulse, zdiv_pulse, summary_pulse, trap_req}), 64'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] k;
      k = 5'($urandom);
      txn(3'($urandom), mk($urandom_range(0,5), k[0]), mk($urandom_range(0,5), k[1]),
          k[2] | k[3], k[4], 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "random");
      if (i % 7 == 0) begin
        @(negedge clk);
        check("R2 idle random", 64'({out_valid, cause_pulse, zdiv_pulse, summary_pulse}), 64'd0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule